// File: doc/BRIEF.md
# Enhanced PWM Generator with Bridge Steering and Fault Shutdown

This block makes one pulse-width-modulated waveform from a free-running timer and sends it to up to four output pins. The pins can act as one single output, as a complementary half-bridge pair with dead time between the two switches, or as a full bridge driven forward or in reverse. The period is set by an 8-bit limit and the duty by a 10-bit value. The timer has a 2-bit fine stage below its 8-bit count, so one timer step is four ticks of the prescaled clock. New period and duty values are held in buffers and only take effect when the timer wraps.

Three fault inputs can each be enabled as a shutdown source. When an enabled fault occurs, a shutdown latch is set and the used pins go to a programmed safe level: low, high or released. The latch can clear by itself once the fault has gone, or wait for a clear written by software. Either way the pins go back to the waveform only at the start of the next period. A clock-enable input stands in for a stopped clock: while it is low, nothing in the block changes.

Configuration is written through a byte-wide register port:
- Address 0: period limit.
- Address 1: upper 8 duty bits.
- Address 2: bits 1:0 are the low duty bits, bits 3:2 the steering mode, bits 5:4 the polarity.
- Address 3: bits 1:0 select the prescale, bit 2 runs the timer.
- Address 4: bits 6:0 set the dead time, bit 7 enables auto-restart.
- Address 5: bits 2:0 enable the fault sources, bits 4:3 give the A/C safe code, bits 6:5 the B/D safe code, and bit 7 requests shutdown (1) or clear (0).

Top module: `epwm_core`

## Requirements
- R1: After reset, every output enable is 0, every pin is 0 and shutdown is 0. The pins stay released until the first period wrap after the timer is started.
- R2: One period lasts (period+1)*4*P clocks, with P = 1 for prescale code 00, 4 for 01 and 16 for 1x. `period_tick` is high for exactly one clock per period.
- R3: In each period the modulated output is active for duty*P clocks, where duty = {upper byte, low 2 bits}. A duty of 0 is never active, and a duty at or above (period+1)*4 is active for the whole period.
- R4: A duty or period written during a period has no effect until the next wrap.
- R5: The steering modes are:
  - 00: single output on A only, enables 0001.
  - 01: full bridge forward. A is steadily active, D is modulated, B and C are inactive, enables 1111.
  - 10: half bridge. A is modulated and B is its complement, enables 0011.
  - 11: full bridge reverse. C is steadily active, B is modulated, A and D are inactive, enables 1111.
  Pins are indexed A=0, B=1, C=2, D=3.
- R6: Polarity bit 0 inverts pins A and C, and polarity bit 1 inverts pins B and D.
- R7: In half-bridge mode each output turns on only after the dead-time count of clocks has passed since the other turned off. Each pin therefore loses that many active clocks per edge, and A and B are never active together.
- R8: An enabled fault sets shutdown on the next clock. Disabled fault inputs are ignored. While shut down, each used pin takes the safe code of its pair: 00 drive low, 01 drive high, 1x release (enable 0). Writing address 5 with bit 7 = 1 also forces shutdown.
- R9: With auto-restart on, shutdown clears one clock after the enabled faults go inactive. With auto-restart off, shutdown stays set until address 5 is written with bit 7 = 0 while no enabled fault is active. A clear written during an active fault has no effect.
- R10: After shutdown clears, the pins keep their safe levels until the next period wrap.
- R11: While `clk_en` is low, the pins, enables and timer hold, `period_tick` stays 0, and register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Clock enable; low freezes the whole block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| fault_in | input | 3 | Fault inputs, active high |
| pwm_out | output | 4 | Pin levels A, B, C, D (bit 0 = A) |
| pwm_oe | output | 4 | Pin output enables |
| period_tick | output | 1 | One-clock pulse at each period wrap |
| shutdown | output | 1 | Shutdown latch status |

## Verification
The waveform is measured by counting the active clocks of each pin over whole periods. The duty is set to 0, to a mid value, to one step below the period and to exactly the period, which tells the strict compare apart from an off-by-one and from wrong full-on handling. Each steering mode, polarity setting, dead time and prescale is counted separately, so a pin wired to the wrong pair or a lost dead-time clock shows up as a count change. The shutdown scenarios use a disabled fault, a latched fault, a forced fault, a clear written during an active fault, and auto-restart. They also check the pins clock by clock until the next wrap, so that a release in the middle of a period is caught.

// File: rtl/epwm_pkg.sv
package epwm_pkg;
  localparam int PR_W   = 8;
  localparam int FINE_W = 2;
  localparam int DUTY_W = PR_W + FINE_W;
  localparam int DB_W   = 7;
  localparam int NFLT   = 3;
  localparam int NPIN   = 4;
  localparam int PS_W   = 4;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd0;
  localparam logic [ADDR_W-1:0] A_DUTYHI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_TIMER  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DEAD   = 3'd4;
  localparam logic [ADDR_W-1:0] A_FAULT  = 3'd5;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_FWD    = 2'b01,
    MODE_HALF   = 2'b10,
    MODE_REV    = 2'b11
  } steer_e;

  typedef struct packed {
    logic [PR_W-1:0]   period;
    logic [DUTY_W-1:0] duty;
    steer_e            mode;
    logic [1:0]        pol;
    logic              run;
    logic [1:0]        presc;
    logic [DB_W-1:0]   db;
    logic              auto_rs;
    logic [NFLT-1:0]   src_en;
    logic [1:0]        safe_ac;
    logic [1:0]        safe_bd;
  } cfg_t;

  // terminal value of the prescale counter: divide by 1, 4 or 16
  function automatic logic [PS_W-1:0] presc_limit(input logic [1:0] sel);
    case (sel)
      2'b00:   return PS_W'(0);
      2'b01:   return PS_W'(3);
      default: return PS_W'(15);
    endcase
  endfunction

  // active while the extended timer position is below the duty value
  function automatic logic duty_active(input logic [DUTY_W-1:0] pos,
                                       input logic [DUTY_W-1:0] duty);
    return pos < duty;
  endfunction

  // active level of each pin before polarity, index A=0 B=1 C=2 D=3
  function automatic logic [NPIN-1:0] steer_active(input steer_e m, input logic p,
                                                   input logic a_on, input logic b_on);
    case (m)
      MODE_SINGLE: return {1'b0, 1'b0, 1'b0, p};
      MODE_FWD:    return {p, 1'b0, 1'b0, 1'b1};
      MODE_HALF:   return {1'b0, 1'b0, b_on, a_on};
      default:     return {1'b0, 1'b1, p, 1'b0};
    endcase
  endfunction

  function automatic logic [NPIN-1:0] steer_used(input steer_e m);
    case (m)
      MODE_SINGLE: return 4'b0001;
      MODE_HALF:   return 4'b0011;
      default:     return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/epwm_regs.sv
module epwm_regs
  import epwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_t              cfg,
  output logic              force_sd,
  output logic              clear_sd
);
  logic wr_ok;
  assign wr_ok    = ce & wr_en;
  assign force_sd = wr_ok & (wr_addr == A_FAULT) & wr_data[7];
  assign clear_sd = wr_ok & (wr_addr == A_FAULT) & ~wr_data[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_ok) begin
      case (wr_addr)
        A_PERIOD: cfg.period <= wr_data[PR_W-1:0];
        A_DUTYHI: cfg.duty[DUTY_W-1:FINE_W] <= wr_data[PR_W-1:0];
        A_CTRL: begin
          cfg.duty[FINE_W-1:0] <= wr_data[FINE_W-1:0];
          cfg.mode             <= steer_e'(wr_data[3:2]);
          cfg.pol              <= wr_data[5:4];
        end
        A_TIMER: begin
          cfg.presc <= wr_data[1:0];
          cfg.run   <= wr_data[2];
        end
        A_DEAD: begin
          cfg.db      <= wr_data[DB_W-1:0];
          cfg.auto_rs <= wr_data[7];
        end
        A_FAULT: begin
          cfg.src_en  <= wr_data[NFLT-1:0];
          cfg.safe_ac <= wr_data[4:3];
          cfg.safe_bd <= wr_data[6:5];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/epwm_timebase.sv
module epwm_timebase
  import epwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              run,
  input  logic [1:0]        presc,
  input  logic [PR_W-1:0]   period_buf,
  input  logic [DUTY_W-1:0] duty_buf,
  output logic              pwm_raw,
  output logic              wrap
);
  logic [PS_W-1:0]   pcnt;
  logic [FINE_W-1:0] fine;
  logic [PR_W-1:0]   tmr;
  logic [PR_W-1:0]   pr_act;
  logic [DUTY_W-1:0] duty_act;
  logic              step;
  logic              fine_end;

  assign step     = ce & run & (pcnt >= presc_limit(presc));
  assign fine_end = (fine == {FINE_W{1'b1}});
  assign wrap     = step & fine_end & (tmr == pr_act);
  assign pwm_raw  = duty_active({tmr, fine}, duty_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt     <= '0;
      fine     <= '0;
      tmr      <= '0;
      pr_act   <= '0;
      duty_act <= '0;
    end else if (ce && run) begin
      pcnt <= step ? '0 : pcnt + 1'b1;
      if (step) begin
        fine <= fine + 1'b1;
        if (fine_end) begin
          if (tmr == pr_act) begin
            tmr      <= '0;
            pr_act   <= period_buf;
            duty_act <= duty_buf;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/epwm_deadband.sv
module epwm_deadband
  import epwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic            en,
  input  logic            raw,
  input  logic [DB_W-1:0] db,
  output logic            p_q,
  output logic            a_on,
  output logic            b_on
);
  logic [DB_W-1:0] cnt;
  logic            quiet;

  assign quiet = (cnt == '0);
  assign a_on  = p_q & quiet;
  assign b_on  = ~p_q & quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= 1'b0;
      cnt <= '0;
    end else if (ce) begin
      if (raw != p_q) begin
        p_q <= raw;
        cnt <= en ? db : '0;
      end else if (!quiet) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/epwm_fault.sv
module epwm_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic fault_hit,
  input  logic force_sd,
  input  logic clear_sd,
  input  logic auto_rs,
  input  logic period_start,
  output logic sd,
  output logic safe_q
);
  logic trip;
  logic release_ok;

  assign trip       = fault_hit | force_sd;
  assign release_ok = ~trip & (auto_rs | clear_sd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd     <= 1'b0;
      safe_q <= 1'b0;
    end else if (ce) begin
      sd <= trip | (sd & ~release_ok);
      if (trip || sd)        safe_q <= 1'b1;
      else if (period_start) safe_q <= 1'b0;
    end
  end
endmodule

// File: rtl/epwm_core.sv
module epwm_core
  import epwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NFLT-1:0]   fault_in,
  output logic [NPIN-1:0]   pwm_out,
  output logic [NPIN-1:0]   pwm_oe,
  output logic              period_tick,
  output logic              shutdown
);
  cfg_t            cfg;
  logic            force_sd, clear_sd;
  logic            pwm_raw, wrap;
  logic            p_q, a_on, b_on;
  logic            fault_hit;
  logic            sd, safe_q;
  logic            run_q;
  logic [NPIN-1:0] act, used;

  // named internal events for the checker
  logic [NFLT-1:0] src_en_w;
  steer_e          mode_w;
  logic [1:0]      pol_w;
  logic            auto_rs_w;
  assign src_en_w  = cfg.src_en;
  assign mode_w    = cfg.mode;
  assign pol_w     = cfg.pol;
  assign auto_rs_w = cfg.auto_rs;

  epwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ce(clk_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg), .force_sd(force_sd), .clear_sd(clear_sd)
  );

  epwm_timebase u_tb (
    .clk(clk), .rst_n(rst_n), .ce(clk_en), .run(cfg.run), .presc(cfg.presc),
    .period_buf(cfg.period), .duty_buf(cfg.duty), .pwm_raw(pwm_raw), .wrap(wrap)
  );

  epwm_deadband u_db (
    .clk(clk), .rst_n(rst_n), .ce(clk_en), .en(cfg.mode == MODE_HALF),
    .raw(pwm_raw), .db(cfg.db), .p_q(p_q), .a_on(a_on), .b_on(b_on)
  );

  assign fault_hit = clk_en & |(fault_in & cfg.src_en);

  epwm_fault u_flt (
    .clk(clk), .rst_n(rst_n), .ce(clk_en), .fault_hit(fault_hit),
    .force_sd(force_sd), .clear_sd(clear_sd), .auto_rs(cfg.auto_rs),
    .period_start(wrap), .sd(sd), .safe_q(safe_q)
  );

  // pins stay released until the first wrap after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_q <= 1'b0;
    else if (clk_en && wrap) run_q <= 1'b1;
  end

  assign act  = steer_active(cfg.mode, p_q, a_on, b_on);
  assign used = steer_used(cfg.mode);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    localparam int PAIR = i % 2;
    logic [1:0] code;
    logic       lvl;
    assign code       = (PAIR == 0) ? cfg.safe_ac : cfg.safe_bd;
    assign lvl        = act[i] ^ cfg.pol[PAIR];
    assign pwm_oe[i]  = run_q & used[i] & ~(safe_q & code[1]);
    assign pwm_out[i] = pwm_oe[i] & (safe_q ? code[0] : lvl);
  end

  assign period_tick = wrap;
  assign shutdown    = sd;
endmodule

// File: rtl/epwm_core_chk.sv
module epwm_core_chk
  import epwm_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            clk_en,
  input logic [NFLT-1:0] fault_in,
  input logic [NFLT-1:0] src_en,
  input steer_e          mode,
  input logic [1:0]      pol,
  input logic            auto_rs,
  input logic            force_sd,
  input logic            safe_q,
  input logic [NPIN-1:0] pwm_out,
  input logic [NPIN-1:0] pwm_oe,
  input logic            period_tick,
  input logic            shutdown
);
  logic seen_tick;
  logic hit;
  assign hit = |(fault_in & src_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     seen_tick <= 1'b0;
    else if (clk_en && period_tick) seen_tick <= 1'b1;
  end

  assert_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_oe != '0) |-> seen_tick);

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HALF && !safe_q && pol == 2'b00) |-> !(pwm_out[0] && pwm_out[1]));

  assert_fault_trips_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && hit) |=> (shutdown && safe_q));

  assert_auto_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && shutdown && auto_rs && !hit && !force_sd) |=> !shutdown);

  assert_resume_on_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(safe_q) |-> $past(period_tick));

  assert_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(pwm_out) && $stable(pwm_oe) && $stable(shutdown)));
endmodule

bind epwm_core epwm_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .fault_in(fault_in),
  .src_en(src_en_w), .mode(mode_w), .pol(pol_w), .auto_rs(auto_rs_w),
  .force_sd(force_sd), .safe_q(safe_q), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
  .period_tick(period_tick), .shutdown(shutdown)
);

// File: tb/epwm_core_tb.sv
`timescale 1ns/1ps
module epwm_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] fault_in = '0;
  logic [3:0] pwm_out, pwm_oe;
  logic       period_tick, shutdown;

  int total = 0;
  int bad = 0;
  int hi [4];
  int cyc;
  int ovl;

  always #2.5 clk = ~clk;

  epwm_core dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fault_in(fault_in), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
    .period_tick(period_tick), .shutdown(shutdown)
  );

  task automatic check(input string tag, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] ctrl(input int low, input int mode, input int pol);
    return 8'(low | (mode << 2) | (pol << 4));
  endfunction

  task automatic sync_tick();
    do @(negedge clk); while (!period_tick);
  endtask

  // count active clocks per pin over n whole periods
  task automatic measure(input int n);
    int seen = 0;
    sync_tick();
    cyc = 0; ovl = 0;
    for (int k = 0; k < 4; k++) hi[k] = 0;
    while (seen < n) begin
      @(negedge clk);
      cyc++;
      for (int k = 0; k < 4; k++) if (pwm_out[k]) hi[k]++;
      if (pwm_out[0] && pwm_out[1]) ovl++;
      if (period_tick) seen++;
    end
  endtask

  task automatic settle();
    sync_tick(); sync_tick();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 oe after reset", int'(pwm_oe), 0);
    check("R1 pins after reset", int'(pwm_out), 0);
    check("R1 shutdown after reset", int'(shutdown), 0);
    wr(3'd0, 8'd9);
    wr(3'd1, 8'd3);
    wr(3'd2, ctrl(1, 0, 0));
    repeat (20) @(negedge clk);
    check("R1 released while timer stopped", int'(pwm_oe), 0);
    wr(3'd3, 8'h04);
    settle();
    check("R1 R5 single enables after wrap", int'(pwm_oe), 4'b0001);
  endtask

  task automatic t_duty();
    measure(2);
    check("R2 period length", cyc, 80);
    check("R3 duty 13", hi[0], 26);
    wr(3'd1, 8'd0); wr(3'd2, ctrl(0, 0, 0)); settle(); measure(2);
    check("R3 duty zero", hi[0], 0);
    wr(3'd1, 8'd9); wr(3'd2, ctrl(3, 0, 0)); settle(); measure(2);
    check("R3 duty one below period", hi[0], 78);
    wr(3'd1, 8'd10); wr(3'd2, ctrl(0, 0, 0)); settle(); measure(2);
    check("R3 duty equal period full", hi[0], 80);
    wr(3'd1, 8'd3); wr(3'd2, ctrl(1, 0, 0)); settle();
  endtask

  task automatic t_buffer();
    int cnt = 0;
    sync_tick();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm_out[0]) cnt++;
      if (i == 20) begin wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'd7; end
      else wr_en = 1'b0;
    end
    check("R4 old duty holds in period", cnt, 13);
    measure(1);
    check("R4 new duty after wrap", hi[0], 29);
    wr(3'd1, 8'd3); settle();
  endtask

  task automatic t_modes();
    wr(3'd2, ctrl(1, 1, 0)); settle(); measure(2);
    check("R5 fwd oe", int'(pwm_oe), 4'b1111);
    check("R5 fwd A steady", hi[0], 80);
    check("R5 fwd D modulated", hi[3], 26);
    check("R5 fwd B+C idle", hi[1] + hi[2], 0);
    wr(3'd2, ctrl(1, 3, 0)); settle(); measure(2);
    check("R5 rev C steady", hi[2], 80);
    check("R5 rev B modulated", hi[1], 26);
    check("R5 rev A+D idle", hi[0] + hi[3], 0);
    wr(3'd2, ctrl(1, 2, 0)); settle(); measure(2);
    check("R5 half oe", int'(pwm_oe), 4'b0011);
    check("R5 half A", hi[0], 26);
    check("R5 half B complement", hi[1], 54);
  endtask

  task automatic t_polarity();
    wr(3'd2, ctrl(1, 2, 3)); settle(); measure(2);
    check("R6 both inverted A", hi[0], 54);
    check("R6 both inverted B", hi[1], 26);
    wr(3'd2, ctrl(1, 2, 1)); settle(); measure(2);
    check("R6 AC inverted A", hi[0], 54);
    check("R6 BD plain B", hi[1], 54);
    wr(3'd2, ctrl(1, 2, 0)); settle();
  endtask

  task automatic t_deadband();
    wr(3'd4, 8'd3); settle(); measure(2);
    check("R7 A shortened", hi[0], 20);
    check("R7 B shortened", hi[1], 48);
    check("R7 no overlap", ovl, 0);
    wr(3'd4, 8'd0); settle();
  endtask

  task automatic t_prescale();
    wr(3'd2, ctrl(1, 0, 0));
    wr(3'd3, 8'h05); settle(); measure(1);
    check("R2 prescale 4 period", cyc, 160);
    check("R3 prescale 4 duty", hi[0], 52);
    wr(3'd3, 8'h06); settle(); measure(1);
    check("R2 prescale 16 period", cyc, 640);
    check("R3 prescale 16 duty", hi[0], 208);
    wr(3'd3, 8'h04); wr(3'd2, ctrl(1, 2, 0)); settle();
  endtask

  task automatic t_fault();
    int miss = 0;
    wr(3'd5, 8'h09);
    fault_in = 3'b010;
    measure(2);
    check("R8 disabled fault ignored", int'(shutdown), 0);
    check("R8 disabled fault A runs", hi[0], 26);
    fault_in = 3'b000;
    sync_tick();
    repeat (5) @(negedge clk);
    fault_in = 3'b001;
    @(negedge clk);
    check("R8 fault latched", int'(shutdown), 1);
    check("R8 safe levels", int'(pwm_out), 4'b0001);
    check("R8 safe enables", int'(pwm_oe), 4'b0011);
    fault_in = 3'b000;
    repeat (50) @(negedge clk);
    check("R9 latch holds without restart", int'(shutdown), 1);
    wr(3'd5, 8'h09);
    check("R9 manual clear", int'(shutdown), 0);
    while (!period_tick) begin
      if (pwm_out != 4'b0001) miss++;
      @(negedge clk);
    end
    if (pwm_out != 4'b0001) miss++;
    check("R10 safe until wrap", miss, 0);
    measure(1);
    check("R10 resumes A", hi[0], 13);
    check("R10 resumes B", hi[1], 27);
  endtask

  task automatic t_force_clear();
    wr(3'd5, 8'h49);
    wr(3'd5, 8'hC9);
    check("R8 forced shutdown", int'(shutdown), 1);
    check("R8 released code enables", int'(pwm_oe), 4'b0001);
    check("R8 released code pins", int'(pwm_out), 4'b0001);
    wr(3'd5, 8'h49);
    check("R9 clear after force", int'(shutdown), 0);
    fault_in = 3'b001;
    repeat (2) @(negedge clk);
    wr(3'd5, 8'h49);
    check("R9 clear ignored during fault", int'(shutdown), 1);
    fault_in = 3'b000;
    wr(3'd5, 8'h49);
    check("R9 clear after fault gone", int'(shutdown), 0);
    wr(3'd4, 8'h80);
    fault_in = 3'b001;
    @(negedge clk);
    check("R9 auto set", int'(shutdown), 1);
    fault_in = 3'b000;
    @(negedge clk);
    check("R9 auto restart", int'(shutdown), 0);
    wr(3'd4, 8'h00);
    settle();
  endtask

  task automatic t_sleep();
    logic [3:0] o, e;
    int moved = 0;
    int ticks = 0;
    sync_tick();
    repeat (7) @(negedge clk);
    clk_en = 1'b0;
    o = pwm_out; e = pwm_oe;
    wr(3'd1, 8'd0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm_out != o || pwm_oe != e) moved++;
      if (period_tick) ticks++;
    end
    check("R11 pins frozen", moved, 0);
    check("R11 no tick asleep", ticks, 0);
    clk_en = 1'b1;
    settle(); measure(2);
    check("R11 write ignored asleep", hi[0], 26);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_duty();
    t_buffer();
    t_modes();
    t_polarity();
    t_deadband();
    t_prescale();
    t_fault();
    t_force_clear();
    t_sleep();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule